// File: doc/BRIEF.md
# Eight-Output Addressable Latch

This block keeps eight single-bit stored outputs. A 3-bit select picks one of them, and that output is written from a single data bit. Two active-low controls are decoded together into four operating modes. The modes are a decoder mode, a latch mode, a hold mode and a clear mode. In decoder mode the selected output takes the data bit and every other output goes low. In latch mode the selected output takes the data bit and the other outputs keep their stored values. In hold mode nothing changes. In clear mode all outputs go low.

The storage is built from registers clocked by a system clock. An output that "follows" the data bit is reloaded on every rising edge while its mode is active. At power-up the contents are unknown until the first clear-mode or decoder-mode cycle. Users drive one of those modes first.

Top module: `addr_latch8`

## Requirements
- R1: The select `sel` is 3 bits wide. Its binary value n chooses output bit `q[n]`, where bit 0 is the least significant bit.
- R2: With `wr_n`=0 and `clr_n`=0 (decoder mode), after a rising edge `q[sel]` equals `din` and every other bit of `q` is 0.
- R3: With `wr_n`=0 and `clr_n`=1 (latch mode), after a rising edge `q[sel]` equals `din` and all other bits keep their previous values.
- R4: With `wr_n`=1 and `clr_n`=1 (hold mode), `q` keeps its value across the edge whatever `din` and `sel` are doing.
- R5: With `wr_n`=1 and `clr_n`=0 (clear mode), after a rising edge `q` is all zeros.
- R6: After any decoder-mode edge, at most one bit of `q` is 1, and only the selected bit may be 1.
- R7: In latch mode, when `sel` changes, the output that was selected before keeps the last value written to it.
- R8: After hold mode is entered from a write mode, `q` keeps the value it had after the last write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every mode takes effect on its rising edge |
| din | input | 1 | Data bit for the selected output |
| sel | input | 3 | Output select |
| wr_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear |
| q | output | 8 | Stored outputs |

## Verification
The assertions assume that the inputs are known at every clock edge. They also assume that `q` has already been set by a clear-mode or decoder-mode edge. For that reason the checks only become active after the first such edge. The bench holds clear mode for its first cycles and only then moves to random and directed mode, select and data patterns. All inputs are driven in the falling half of the clock, so they never change at the sampling edge.

// File: rtl/addr_latch8.sv
module addr_latch8 #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_n,
  input  logic             clr_n,
  output logic [N-1:0]     q
);

  logic [N-1:0] hit;
  logic [N-1:0] nxt;

  assign hit = N'(1) << sel;

  always_comb begin
    unique case ({wr_n, clr_n})
      2'b00: nxt = din ? hit : '0;
      2'b01: nxt = din ? (q | hit) : (q & ~hit);
      2'b10: nxt = '0;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) q <= nxt;

  logic known = 1'b0;
  always_ff @(posedge clk) if (!wr_n && !clr_n || wr_n && !clr_n) known <= 1'b1;

  AST_DEMUX_SEL: assert property (@(posedge clk) disable iff (!known)
    (!wr_n && !clr_n) |=> q[$past(sel)] == $past(din)); // R2
  AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (!known)
    (!wr_n && !clr_n) |=> $onehot0(q) && ((q & ~(N'(1) << $past(sel))) == '0)); // R6
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!known)
    (!wr_n && clr_n) |=> q[$past(sel)] == $past(din)); // R3
  AST_LATCH_OTHERS: assert property (@(posedge clk) disable iff (!known)
    (!wr_n && clr_n) |=> $countones((q ^ $past(q)) & ~(N'(1) << $past(sel))) == 0); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!known)
    (wr_n && clr_n) |=> $stable(q)); // R4
  AST_CLEAR: assert property (@(posedge clk)
    (wr_n && !clr_n) |=> q == '0); // R5

endmodule

// File: tb/addr_latch8_tb.sv
module addr_latch8_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic din = 0;
  logic [2:0] sel = 0;
  logic wr_n = 1;
  logic clr_n = 0;
  logic [7:0] q;

  int vectors = 0;
  int errors = 0;
  bit model [8];

  addr_latch8 u_dut (.clk(clk), .din(din), .sel(sel), .wr_n(wr_n), .clr_n(clr_n), .q(q));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model_step(bit w, bit c, int s, bit d);
    if (!w && !c) begin
      foreach (model[i]) model[i] = 0;
      model[s] = d;
    end else if (!w && c) model[s] = d;
    else if (w && !c) foreach (model[i]) model[i] = 0;
  endfunction

  task automatic step(bit w, bit c, int s, bit d, string tag);
    logic [7:0] exp;
    @(negedge clk);
    wr_n = w; clr_n = c; sel = 3'(s); din = d;
    model_step(w, c, s, d);
    @(negedge clk);
    for (int i = 0; i < 8; i++) exp[i] = model[i];
    vectors++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b (wr_n=%0b clr_n=%0b sel=%0d din=%0b)", tag, q, exp, w, c, s, d);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    step(1, 0, 0, 1, "R5 reset state");
    step(1, 0, 5, 1, "R5 clear holds zero");
    for (int s = 0; s < 8; s++) step(0, 1, s, 1, "R1 R3 latch fill");
    step(0, 1, 3, 0, "R3 latch write zero");
    step(0, 1, 6, 0, "R7 previous select keeps value");
    step(1, 1, 0, 0, "R4 R8 hold");
    for (int s = 0; s < 8; s++) step(1, 1, s, s[0], "R4 hold ignores din/sel");
    for (int s = 0; s < 8; s++) step(0, 0, s, 1, "R2 R6 demux one-hot");
    step(0, 0, 4, 0, "R2 R6 demux zero");
    step(1, 0, 2, 1, "R5 clear");
    step(0, 1, 7, 1, "R3 latch bit7");
    step(0, 1, 0, 1, "R7 bit7 retained");
    step(0, 0, 1, 1, "R2 demux clears others");
    for (int k = 0; k < 400; k++) begin
      bit w = 1'($urandom);
      bit c = 1'($urandom);
      step(w, c, int'($urandom_range(0, 7)), 1'($urandom), "R2 R3 R4 R5 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule